// File: doc/BRIEF.md
# 64-bit Integer ALU with Three-Way Compare

This block is the integer execution unit of a register machine with 64-bit registers. Each cycle it can accept one operation: an 8-bit operation code and two 64-bit operands. The second operand is either a register value or an immediate; that choice is made upstream. The block computes one 64-bit result and registers it. Both the register form and the immediate form of an operation select the same arithmetic.

The unit covers wrapping add, subtract and multiply, bitwise AND/OR/XOR, logical and arithmetic shifts, bitwise and logical negation, and signed and unsigned three-way comparison. A comparison returns a full-width value of -1, 0 or +1 rather than a flag, so it can be written straight back to a register. Any operation code outside this set produces a zero result and raises an unsupported indication, so that the surrounding pipeline can route it elsewhere or trap.

Top module: `alu64_cmp3`

## Requirements
- R1: Codes 3 (add), 17 (add, immediate form) and 4 (subtract, a-b) return the result modulo 2^64; carries and borrows out of bit 63 are lost.
- R2: Codes 5 and 18 return the low 64 bits of the product a*b.
- R3: Codes 6/19 return a AND b, codes 7/20 return a OR b, and codes 8/21 return a XOR b.
- R4: Codes 9/22 shift a left and codes 10/23 shift a right logically. Both fill with zeros, and only bits [5:0] of b set the shift distance.
- R5: Codes 11/24 shift a right arithmetically by b[5:0] and fill the vacated bits with copies of a[63].
- R6: Codes 12/25 compare a with b as signed two's-complement numbers. The result is all ones when a<b, zero when a==b, and 1 when a>b.
- R7: Codes 13/26 perform the same three-way comparison with both operands treated as unsigned.
- R8: Code 15 returns the bitwise complement of a; the value of b has no effect on the result.
- R9: Code 16 returns 1 when a is zero and 0 otherwise; the value of b has no effect on the result.
- R10: Any other code (for example 0, 14, 27 or 255) returns a zero result with unsupported=1; every listed code returns unsupported=0.
- R11: result and unsupported appear one clock after a cycle with in_valid=1, and out_valid is high exactly in that following cycle. The outputs hold their value while in_valid is low. Reset clears out_valid, result and unsupported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| opcode | input | 8 | Operation code |
| operand_a | input | 64 | First operand |
| operand_b | input | 64 | Second operand (register or immediate) |
| out_valid | output | 1 | Result registered from the previous cycle |
| result | output | 64 | Operation result |
| unsupported | output | 1 | Operation code not handled by this unit |

## Verification
The cases that are hardest to reach are shift distances of 64 or more, where only the low six bits may count, and comparisons whose signed and unsigned outcomes differ. These last need operands that straddle the sign bit. The stimulus drives shift distances of 65 and 127, and compares negative numbers against small positive ones in both comparison modes. It also sends the negation codes with a nonzero, random-looking b to show that b is ignored. Operations are issued back to back and with idle gaps in between, so that the one-cycle timing and the holding of outputs are both exercised.

// File: rtl/alu64_pkg.sv
package alu64_pkg;

    localparam int OPC_W = 8;

    typedef enum logic [3:0] {
        K_ADD,
        K_SUB,
        K_MUL,
        K_AND,
        K_OR,
        K_XOR,
        K_SHL,
        K_SHR,
        K_SAR,
        K_CMP,
        K_BNOT,
        K_LNOT,
        K_NONE
    } op_kind_e;

    typedef struct packed {
        op_kind_e kind;
        logic     cmp_signed;
        logic     unsup;
    } op_sel_t;

endpackage

// File: rtl/alu64_decode.sv
module alu64_decode
    import alu64_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output op_sel_t          sel
);

    always_comb begin
        sel.kind       = K_NONE;
        sel.cmp_signed = 1'b0;
        sel.unsup      = 1'b0;
        case (opcode)
            8'd3,  8'd17: sel.kind = K_ADD;
            8'd4:         sel.kind = K_SUB;
            8'd5,  8'd18: sel.kind = K_MUL;
            8'd6,  8'd19: sel.kind = K_AND;
            8'd7,  8'd20: sel.kind = K_OR;
            8'd8,  8'd21: sel.kind = K_XOR;
            8'd9,  8'd22: sel.kind = K_SHL;
            8'd10, 8'd23: sel.kind = K_SHR;
            8'd11, 8'd24: sel.kind = K_SAR;
            8'd12, 8'd25: begin
                sel.kind       = K_CMP;
                sel.cmp_signed = 1'b1;
            end
            8'd13, 8'd26: sel.kind = K_CMP;
            8'd15:        sel.kind = K_BNOT;
            8'd16:        sel.kind = K_LNOT;
            default:      sel.unsup = 1'b1;
        endcase
    end

    // R10: the unsupported mark and the "no operation" class always agree
    always_comb begin
        assert_unsup_class_R10: assert (sel.unsup == (sel.kind == K_NONE));
    end

endmodule

// File: rtl/alu64_shift.sv
module alu64_shift #(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0]         value,
    input  logic [$clog2(WIDTH)-1:0] amount,
    output logic [WIDTH-1:0]         shl,
    output logic [WIDTH-1:0]         shr,
    output logic [WIDTH-1:0]         sar
);

    localparam int STAGES = $clog2(WIDTH);

    logic [WIDTH-1:0] l_stage [STAGES+1];
    logic [WIDTH-1:0] r_stage [STAGES+1];
    logic [WIDTH-1:0] a_stage [STAGES+1];

    assign l_stage[0] = value;
    assign r_stage[0] = value;
    assign a_stage[0] = value;

    // log-depth barrel: stage k moves by 2**k when amount[k] is set
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        localparam int DIST = 1 << k;
        assign l_stage[k+1] = amount[k] ? {l_stage[k][WIDTH-DIST-1:0], {DIST{1'b0}}}
                                        : l_stage[k];
        assign r_stage[k+1] = amount[k] ? {{DIST{1'b0}}, r_stage[k][WIDTH-1:DIST]}
                                        : r_stage[k];
        assign a_stage[k+1] = amount[k] ? {{DIST{value[WIDTH-1]}}, a_stage[k][WIDTH-1:DIST]}
                                        : a_stage[k];
    end

    assign shl = l_stage[STAGES];
    assign shr = r_stage[STAGES];
    assign sar = a_stage[STAGES];

    logic [WIDTH-1:0] low_mask;
    logic [WIDTH-1:0] high_mask;
    always_comb begin
        low_mask  = ({WIDTH{1'b1}} << amount) ^ {WIDTH{1'b1}};
        high_mask = ({WIDTH{1'b1}} >> amount) ^ {WIDTH{1'b1}};
    end

    // R4: vacated positions are zero for both logical directions
    always_comb begin
        assert_shl_zero_fill_R4: assert ((shl & low_mask) == '0);
        assert_shr_zero_fill_R4: assert ((shr & high_mask) == '0);
    end

    // R5: vacated positions carry the sign bit
    always_comb begin
        assert_sar_sign_fill_R5: assert ((sar & high_mask) == (value[WIDTH-1] ? high_mask : '0));
    end

endmodule

// File: rtl/alu64_cmp.sv
module alu64_cmp #(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] lhs,
    input  logic [WIDTH-1:0] rhs,
    input  logic             is_signed,
    output logic [WIDTH-1:0] order
);

    logic less;
    logic same;

    always_comb begin
        same = (lhs == rhs);
        if (is_signed) begin
            less = ($signed(lhs) < $signed(rhs));
        end else begin
            less = (lhs < rhs);
        end
        if (less) begin
            order = {WIDTH{1'b1}};
        end else if (same) begin
            order = '0;
        end else begin
            order = WIDTH'(1);
        end
    end

    // R6 / R7: the outcome is one of -1, 0, +1
    always_comb begin
        assert_cmp_range_R6: assert (order == '0 || order == WIDTH'(1) || order == {WIDTH{1'b1}});
        assert_cmp_equal_R7: assert ((order == '0) == (lhs == rhs));
    end

endmodule

// File: rtl/alu64_cmp3.sv
module alu64_cmp3
    import alu64_pkg::*;
#(
    parameter int WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       opcode,
    input  logic [WIDTH-1:0] operand_a,
    input  logic [WIDTH-1:0] operand_b,
    output logic             out_valid,
    output logic [WIDTH-1:0] result,
    output logic             unsupported
);

    localparam int SHW = $clog2(WIDTH);

    typedef struct packed {
        logic             valid;
        logic [WIDTH-1:0] value;
        logic             unsup;
    } out_reg_t;

    op_sel_t          sel;
    logic [WIDTH-1:0] shl_v;
    logic [WIDTH-1:0] shr_v;
    logic [WIDTH-1:0] sar_v;
    logic [WIDTH-1:0] cmp_v;
    logic [WIDTH-1:0] calc_v;
    out_reg_t         out_d;
    out_reg_t         out_q;

    alu64_decode u_decode (
        .opcode (opcode),
        .sel    (sel)
    );

    alu64_shift #(.WIDTH(WIDTH)) u_shift (
        .value  (operand_a),
        .amount (operand_b[SHW-1:0]),
        .shl    (shl_v),
        .shr    (shr_v),
        .sar    (sar_v)
    );

    alu64_cmp #(.WIDTH(WIDTH)) u_cmp (
        .lhs       (operand_a),
        .rhs       (operand_b),
        .is_signed (sel.cmp_signed),
        .order     (cmp_v)
    );

    always_comb begin
        case (sel.kind)
            K_ADD:   calc_v = operand_a + operand_b;
            K_SUB:   calc_v = operand_a - operand_b;
            K_MUL:   calc_v = operand_a * operand_b;
            K_AND:   calc_v = operand_a & operand_b;
            K_OR:    calc_v = operand_a | operand_b;
            K_XOR:   calc_v = operand_a ^ operand_b;
            K_SHL:   calc_v = shl_v;
            K_SHR:   calc_v = shr_v;
            K_SAR:   calc_v = sar_v;
            K_CMP:   calc_v = cmp_v;
            K_BNOT:  calc_v = ~operand_a;
            K_LNOT:  calc_v = WIDTH'(operand_a == '0);
            default: calc_v = '0;
        endcase

        out_d       = out_q;
        out_d.valid = in_valid;
        if (in_valid) begin
            out_d.value = calc_v;
            out_d.unsup = sel.unsup;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_valid   = out_q.valid;
    assign result      = out_q.value;
    assign unsupported = out_q.unsup;

    // R11: one-cycle latency and hold while idle
    assert_valid_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(unsupported)));

    // R10: an unsupported code leaves a zero result
    assert_unsup_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && unsupported) |-> (result == '0));

    // R9: logical negation gives 0 or 1 only
    assert_lnot_bool_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 8'd16) |=> (result[WIDTH-1:1] == '0));

endmodule

// File: tb/alu64_cmp3_tb.sv
module alu64_cmp3_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct {
        logic [63:0] value;
        logic        unsup;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  opcode = '0;
    logic [63:0] operand_a = '0;
    logic [63:0] operand_b = '0;
    logic        out_valid;
    logic [63:0] result;
    logic        unsupported;

    int   total = 0;
    int   bad = 0;
    exp_t sb [$];
    bit   done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu64_cmp3 u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .opcode      (opcode),
        .operand_a   (operand_a),
        .operand_b   (operand_b),
        .out_valid   (out_valid),
        .result      (result),
        .unsupported (unsupported)
    );

    function automatic logic [63:0] cmp3(input logic lt, input logic eq);
        if (lt) return 64'hFFFF_FFFF_FFFF_FFFF;
        if (eq) return 64'd0;
        return 64'd1;
    endfunction

    function automatic exp_t model(input logic [7:0] op, input logic [63:0] a,
                                   input logic [63:0] b, input string tag);
        exp_t e;
        e.unsup = 1'b0;
        e.tag   = tag;
        case (op)
            8'd3, 8'd17:  e.value = a + b;
            8'd4:         e.value = a - b;
            8'd5, 8'd18:  e.value = a * b;
            8'd6, 8'd19:  e.value = a & b;
            8'd7, 8'd20:  e.value = a | b;
            8'd8, 8'd21:  e.value = a ^ b;
            8'd9, 8'd22:  e.value = a << b[5:0];
            8'd10, 8'd23: e.value = a >> b[5:0];
            8'd11, 8'd24: e.value = $unsigned($signed(a) >>> b[5:0]);
            8'd12, 8'd25: e.value = cmp3($signed(a) < $signed(b), a == b);
            8'd13, 8'd26: e.value = cmp3(a < b, a == b);
            8'd15:        e.value = ~a;
            8'd16:        e.value = (a == 64'd0) ? 64'd1 : 64'd0;
            default: begin
                e.value = 64'd0;
                e.unsup = 1'b1;
            end
        endcase
        return e;
    endfunction

    // driver: issue one operation, push its expectation
    task automatic drive(input logic [7:0] op, input logic [63:0] a,
                         input logic [63:0] b, input string tag);
        @(negedge clk);
        in_valid  = 1'b1;
        opcode    = op;
        operand_a = a;
        operand_b = b;
        sb.push_back(model(op, a, b, tag));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid  = 1'b0;
            opcode    = 8'hA5;
            operand_a = 64'h1234_5678_9ABC_DEF0;
            operand_b = 64'h0FED_CBA9_8765_4321;
        end
    endtask

    // monitor: compare each registered result against the queue head
    logic [63:0] held_value;
    logic        held_unsup;
    initial begin
        held_value = '0;
        held_unsup = 1'b0;
        @(posedge rst_n);
        forever begin
            @(posedge clk);
            #1;
            if (done) break;
            if (out_valid) begin
                if (sb.size() == 0) begin
                    total++; bad++;
                    $display("FAIL R11: out_valid with nothing issued (actual=1 expected=0)");
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    total++;
                    if (result !== e.value || unsupported !== e.unsup) begin
                        bad++;
                        $display("FAIL %s: actual=%h/%b expected=%h/%b",
                                 e.tag, result, unsupported, e.value, e.unsup);
                    end
                end
                held_value = result;
                held_unsup = unsupported;
            end else begin
                total++;
                if (result !== held_value || unsupported !== held_unsup) begin
                    bad++;
                    $display("FAIL R11: idle output moved actual=%h/%b expected=%h/%b",
                             result, unsupported, held_value, held_unsup);
                end
            end
        end
    end

    initial begin
        int cycles;
        cycles = 0;
        while (!done && cycles < WATCHDOG) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d cycles expected=<%0d", cycles, WATCHDOG);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        total++;
        if (out_valid !== 1'b0 || result !== 64'd0 || unsupported !== 1'b0) begin
            bad++;
            $display("FAIL R11: reset state actual=%b/%h/%b expected=0/0/0",
                     out_valid, result, unsupported);
        end
        rst_n = 1'b1;
        idle(2);

        // R1 wrapping add/sub
        drive(8'd3,  64'd100, 64'd23, "R1 add");
        drive(8'd3,  64'hFFFF_FFFF_FFFF_FFFF, 64'd1, "R1 add wrap");
        drive(8'd17, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0005, "R1 addi wrap");
        drive(8'd4,  64'd0, 64'd1, "R1 sub borrow");
        drive(8'd4,  64'd50, 64'd8, "R1 sub");
        idle(1);
        // R2 multiply low half
        drive(8'd5,  64'h1_0000_0000, 64'h1_0000_0000, "R2 mul wrap");
        drive(8'd18, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, "R2 muli neg");
        drive(8'd5,  64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, "R2 mul mixed");
        // R3 logic
        drive(8'd6,  64'hF0F0_F0F0_F0F0_F0F0, 64'h0FF0_0FF0_0FF0_0FF0, "R3 and");
        drive(8'd19, 64'hDEAD_BEEF_0000_FFFF, 64'h0000_FFFF_FFFF_0000, "R3 andi");
        drive(8'd7,  64'hA000_0000_0000_000A, 64'h0500_0000_0000_0050, "R3 or");
        drive(8'd20, 64'd0, 64'h1357_9BDF_2468_ACE0, "R3 ori");
        drive(8'd8,  64'hFFFF_0000_FFFF_0000, 64'hFF00_FF00_FF00_FF00, "R3 xor");
        drive(8'd21, 64'h5555_5555_5555_5555, 64'hFFFF_FFFF_FFFF_FFFF, "R3 xori");
        idle(2);
        // R4 logical shifts, distance from low 6 bits only
        drive(8'd9,  64'h8000_0000_0000_0001, 64'd4, "R4 shl");
        drive(8'd22, 64'h0000_0000_0000_00F3, 64'd65, "R4 shli 65");
        drive(8'd9,  64'hFFFF_FFFF_FFFF_FFFF, 64'd63, "R4 shl 63");
        drive(8'd10, 64'h8000_0000_0000_0000, 64'd63, "R4 shr 63");
        drive(8'd23, 64'hF000_0000_0000_000F, 64'd127, "R4 shri 127");
        drive(8'd10, 64'hABCD, 64'h40, "R4 shr 64 as 0");
        // R5 arithmetic shift
        drive(8'd11, 64'h8000_0000_0000_0000, 64'd8, "R5 sar neg");
        drive(8'd24, 64'h7FFF_FFFF_FFFF_FFFF, 64'd60, "R5 sari pos");
        drive(8'd11, 64'hF000_0000_0000_0000, 64'd66, "R5 sar 66");
        idle(1);
        // R6 signed compare
        drive(8'd12, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, "R6 cmp lt");
        drive(8'd12, 64'd7, 64'hFFFF_FFFF_FFFF_FFF0, "R6 cmp gt");
        drive(8'd25, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, "R6 cmpi eq");
        drive(8'd25, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, "R6 cmpi min");
        // R7 unsigned compare
        drive(8'd13, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, "R7 cmpu gt");
        drive(8'd13, 64'd1, 64'h8000_0000_0000_0000, "R7 cmpu lt");
        drive(8'd26, 64'd42, 64'd42, "R7 cmpui eq");
        // R8 bitwise negation ignores b
        drive(8'd15, 64'h0F0F_0000_FFFF_1234, 64'hDEAD_BEEF_DEAD_BEEF, "R8 bnot");
        drive(8'd15, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, "R8 bnot zero");
        // R9 logical negation ignores b
        drive(8'd16, 64'd0, 64'h1234_0000_0000_0001, "R9 lnot zero");
        drive(8'd16, 64'd5, 64'd0, "R9 lnot nonzero");
        drive(8'd16, 64'h8000_0000_0000_0000, 64'hFFFF, "R9 lnot msb");
        idle(3);
        // R10 unsupported codes
        drive(8'd0,   64'hFFFF, 64'hFFFF, "R10 code 0");
        drive(8'd14,  64'd9, 64'd3, "R10 code 14");
        drive(8'd27,  64'd1, 64'd1, "R10 code 27");
        drive(8'd255, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, "R10 code 255");
        drive(8'd3,   64'd1, 64'd1, "R10 supported after unsupported");
        idle(4);

        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule